// File: doc/BRIEF.md
# NOR Flash Command Interpreter

This block is a synthesizable, device-side behavioural model of a NOR flash command state machine. It serves as a self-checking target for a host-side flash sequencer. The host drives byte-wide bus writes that the block decodes into commands: array read, status read, error clear, block erase, buffered program, block lock and unlock, and erase suspend and resume. All of these act on a small internal memory that carries one lock bit per block.

The block keeps a status byte with a ready flag, an erase-suspended flag and sticky error flags. Parameterised cycle counters stand in for the time real cells take to program, erase or change a lock bit. An erase can be suspended part-way, and its remaining time is kept across the suspension. While an erase is suspended, the host can read other blocks.

A bus read returns data in the cycle after the address is presented. The data comes from the array or from the status byte, depending on the current read mode.

Top module: `nor_cmd_model`

## Requirements
- R1: After reset the block is in array read mode, the status byte reads 0x80, no block is locked, and every array byte reads 0xFF.
- R2: A write of 0xFF selects array reads and a write of 0x70 selects status reads. The read data for an address appears one clock cycle after the address is presented with the write enable low.
- R3: Status bit 7 reads 0 while an erase, program or lock change is in progress, and 1 at all other times.
- R4: A write of 0x20 followed by 0xD0 erases the block addressed by the confirm write. All bytes of that block become 0xFF, the operation stays busy for exactly T_ERASE cycles, and status read mode is selected.
- R5: A write of 0xE8, then a count N-1, then N data words, then 0xD0 programs N bytes. The bytes start at the address of the first data word and continue at consecutive offsets that wrap inside that word's block. Each stored byte becomes the old value ANDed with the new data.
- R6: A count byte of BUF_DEPTH or more sets status bits 5 and 4 and abandons the program sequence.
- R7: A confirm byte that does not match the second write of an erase, program or lock sequence sets status bits 5 and 4 and changes nothing in the array.
- R8: A write of 0x60 followed by 0x01 locks the addressed block, and 0x60 followed by 0xD0 unlocks it. Each is busy for T_LOCK cycles.
- R9: An erase or program aimed at a locked block sets status bit 1, never goes busy, and leaves the array unchanged.
- R10: The error flags (bits 5, 4 and 1; bit 3 always reads 0) stay set until a write of 0x50 clears them.
- R11: A write of 0xB0 during an erase suspends it, so the status reads 0xC0 and other blocks can be read in array mode. A write of 0xD0 resumes the erase, which then finishes after exactly its remaining cycles.
- R12: A write of 0x70 during an erase switches to status reads without delaying or disturbing the erase.
- R13: The block ignores an unrecognised byte written while idle. While an erase is suspended, it ignores any byte other than 0xFF, 0x70, 0x50 and 0xD0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe; when low, the cycle is a read of bus_addr |
| bus_addr | input | ADDR_W | Byte address (block index in the upper bits) |
| bus_wdata | input | 8 | Command or data byte |
| bus_rdata | output | 8 | Array byte or status byte, one cycle after the address |

## Verification
The hardest state to reach from the ports is a suspended erase whose remaining time must be carried across the suspension exactly. The bench suspends an erase a known number of cycles after the confirm write. During the suspension it reads another block and the target block, and writes a command that must be ignored. It then resumes and samples the status in the last busy cycle and again in the first ready cycle. Without a resume that starts from the saved count, those two samples cannot both match. The erase that takes a 0x70 write in mid-flight is timed to the cycle in the same way.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;
  localparam logic [7:0] CMD_READ_ARRAY = 8'hFF;
  localparam logic [7:0] CMD_READ_STAT  = 8'h70;
  localparam logic [7:0] CMD_CLEAR      = 8'h50;
  localparam logic [7:0] CMD_ERASE      = 8'h20;
  localparam logic [7:0] CMD_CONFIRM    = 8'hD0;
  localparam logic [7:0] CMD_LOCK_SETUP = 8'h60;
  localparam logic [7:0] CMD_LOCK_SET   = 8'h01;
  localparam logic [7:0] CMD_BUF_PROG   = 8'hE8;
  localparam logic [7:0] CMD_SUSPEND    = 8'hB0;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ERASE_CFM,
    ST_LOCK_CFM,
    ST_PB_COUNT,
    ST_PB_DATA,
    ST_PB_CFM,
    ST_ERASING,
    ST_ESUSP,
    ST_PROG_WAIT,
    ST_PROG_RD,
    ST_PROG_WR,
    ST_LOCKING
  } state_t;
endpackage

// File: rtl/nor_cmd_array.sv
module nor_cmd_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // erased contents at configuration time
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '1;
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/nor_cmd_lockbits.sv
module nor_cmd_lockbits #(
  parameter int NUM_BLKS = 4,
  parameter int IDX_W    = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                upd,
  input  logic [IDX_W-1:0]    upd_idx,
  input  logic                upd_val,
  output logic [NUM_BLKS-1:0] locked
);
  for (genvar b = 0; b < NUM_BLKS; b++) begin : g_blk
    always_ff @(posedge clk) begin
      if (rst) locked[b] <= 1'b0;
      else if (upd && upd_idx == IDX_W'(b)) locked[b] <= upd_val;
    end
  end
endmodule

// File: rtl/nor_cmd_wbuf.sv
module nor_cmd_wbuf #(
  parameter int DEPTH  = 8,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (we && widx == IDX_W'(i)) slot[i] <= wdata;
    end
  end

  assign rdata = slot[ridx];
endmodule

// File: rtl/nor_cmd_model.sv
module nor_cmd_model
  import nor_cmd_pkg::*;
#(
  parameter int BLK_BITS  = 4,
  parameter int NUM_BLKS  = 4,
  parameter int BUF_DEPTH = 8,
  parameter int T_ERASE   = 40,
  parameter int T_PROG    = 12,
  parameter int T_LOCK    = 6,
  localparam int BLK_IDX_W = $clog2(NUM_BLKS),
  localparam int ADDR_W    = BLK_IDX_W + BLK_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata
);
  localparam int BLK_SIZE  = 1 << BLK_BITS;
  localparam int BUF_IDX_W = $clog2(BUF_DEPTH);
  localparam int T_MAX     = (T_ERASE > T_PROG) ? ((T_ERASE > T_LOCK) ? T_ERASE : T_LOCK)
                                                : ((T_PROG > T_LOCK) ? T_PROG : T_LOCK);
  localparam int CNT_W     = $clog2(T_MAX + 1);

  state_t                 state;
  logic                   rd_stat;
  logic                   err_e, err_p, err_l;
  logic [CNT_W-1:0]       cnt;
  logic [BLK_IDX_W-1:0]   op_blk;
  logic                   lock_val;
  logic [BUF_IDX_W-1:0]   pb_len, pb_idx;
  logic [BLK_BITS-1:0]    pb_off;

  logic [NUM_BLKS-1:0]    locked;
  logic [7:0]             buf_q, mem_q, stat_q, status_now;
  logic                   sel_q, ready;
  logic                   arr_we;
  logic [ADDR_W-1:0]      arr_waddr, arr_raddr;
  logic [7:0]             arr_wdata;
  logic [BLK_BITS-1:0]    erase_off, prog_off;
  logic [BLK_IDX_W-1:0]   bus_blk;
  logic                   susp_req, cmd_is_stat;

  assign bus_blk     = bus_addr[ADDR_W-1:BLK_BITS];
  assign susp_req    = bus_we && bus_wdata == CMD_SUSPEND;
  assign cmd_is_stat = bus_we && bus_wdata == CMD_READ_STAT;
  assign erase_off   = cnt[BLK_BITS-1:0] - 1'b1;
  assign prog_off    = pb_off + BLK_BITS'(pb_idx);

  assign ready = !(state inside {ST_ERASING, ST_PROG_WAIT, ST_PROG_RD, ST_PROG_WR, ST_LOCKING});
  assign status_now = {ready, state == ST_ESUSP, err_e, err_p, 1'b0, 1'b0, err_l, 1'b0};

  // array port steering
  always_comb begin
    arr_we    = 1'b0;
    arr_waddr = {op_blk, erase_off};
    arr_wdata = '1;
    arr_raddr = bus_addr;
    if (state == ST_ERASING && !susp_req && int'(cnt) <= BLK_SIZE) arr_we = 1'b1;
    if (state == ST_PROG_WR) begin
      arr_we    = 1'b1;
      arr_waddr = {op_blk, prog_off};
      arr_wdata = mem_q & buf_q;
    end
    if (state == ST_PROG_RD) arr_raddr = {op_blk, prog_off};
  end

  nor_cmd_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
    .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
    .raddr(arr_raddr), .rdata(mem_q)
  );

  nor_cmd_lockbits #(.NUM_BLKS(NUM_BLKS), .IDX_W(BLK_IDX_W)) u_locks (
    .clk(clk), .rst(rst),
    .upd(state == ST_LOCKING && cnt == CNT_W'(1)),
    .upd_idx(op_blk), .upd_val(lock_val), .locked(locked)
  );

  nor_cmd_wbuf #(.DEPTH(BUF_DEPTH), .IDX_W(BUF_IDX_W), .DATA_W(8)) u_wbuf (
    .clk(clk), .we(bus_we && state == ST_PB_DATA), .widx(pb_idx),
    .wdata(bus_wdata), .ridx(pb_idx), .rdata(buf_q)
  );

  // command state machine
  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      rd_stat  <= 1'b0;
      err_e    <= 1'b0;
      err_p    <= 1'b0;
      err_l    <= 1'b0;
      cnt      <= '0;
      op_blk   <= '0;
      lock_val <= 1'b0;
      pb_len   <= '0;
      pb_idx   <= '0;
      pb_off   <= '0;
    end else begin
      if (!ready && cmd_is_stat) rd_stat <= 1'b1;
      case (state)
        ST_IDLE: if (bus_we) begin
          case (bus_wdata)
            CMD_READ_ARRAY: rd_stat <= 1'b0;
            CMD_READ_STAT:  rd_stat <= 1'b1;
            CMD_CLEAR: begin
              err_e <= 1'b0; err_p <= 1'b0; err_l <= 1'b0;
            end
            CMD_ERASE:      begin state <= ST_ERASE_CFM; rd_stat <= 1'b1; end
            CMD_LOCK_SETUP: begin state <= ST_LOCK_CFM;  rd_stat <= 1'b1; end
            CMD_BUF_PROG:   begin state <= ST_PB_COUNT;  rd_stat <= 1'b1; end
            default: ;
          endcase
        end
        ST_ERASE_CFM: if (bus_we) begin
          if (bus_wdata == CMD_CONFIRM) begin
            op_blk <= bus_blk;
            if (locked[bus_blk]) begin
              err_l <= 1'b1;
              state <= ST_IDLE;
            end else begin
              cnt   <= CNT_W'(T_ERASE);
              state <= ST_ERASING;
            end
          end else begin
            err_e <= 1'b1; err_p <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_LOCK_CFM: if (bus_we) begin
          if (bus_wdata == CMD_LOCK_SET || bus_wdata == CMD_CONFIRM) begin
            op_blk   <= bus_blk;
            lock_val <= (bus_wdata == CMD_LOCK_SET);
            cnt      <= CNT_W'(T_LOCK);
            state    <= ST_LOCKING;
          end else begin
            err_e <= 1'b1; err_p <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_PB_COUNT: if (bus_we) begin
          if (int'(bus_wdata) >= BUF_DEPTH) begin
            err_e <= 1'b1; err_p <= 1'b1;
            state <= ST_IDLE;
          end else begin
            pb_len <= bus_wdata[BUF_IDX_W-1:0];
            pb_idx <= '0;
            state  <= ST_PB_DATA;
          end
        end
        ST_PB_DATA: if (bus_we) begin
          if (pb_idx == '0) begin
            op_blk <= bus_blk;
            pb_off <= bus_addr[BLK_BITS-1:0];
          end
          if (pb_idx == pb_len) begin
            pb_idx <= '0;
            state  <= ST_PB_CFM;
          end else begin
            pb_idx <= pb_idx + 1'b1;
          end
        end
        ST_PB_CFM: if (bus_we) begin
          if (bus_wdata == CMD_CONFIRM) begin
            if (locked[op_blk]) begin
              err_l <= 1'b1;
              state <= ST_IDLE;
            end else begin
              cnt   <= CNT_W'(T_PROG);
              state <= ST_PROG_WAIT;
            end
          end else begin
            err_e <= 1'b1; err_p <= 1'b1;
            state <= ST_IDLE;
          end
        end
        ST_ERASING: begin
          if (susp_req) begin
            rd_stat <= 1'b1;
            state   <= ST_ESUSP;
          end else if (cnt == CNT_W'(1)) begin
            state <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_ESUSP: if (bus_we) begin
          case (bus_wdata)
            CMD_CONFIRM:    begin state <= ST_ERASING; rd_stat <= 1'b1; end
            CMD_READ_ARRAY: rd_stat <= 1'b0;
            CMD_READ_STAT:  rd_stat <= 1'b1;
            CMD_CLEAR: begin
              err_e <= 1'b0; err_p <= 1'b0; err_l <= 1'b0;
            end
            default: ;
          endcase
        end
        ST_PROG_WAIT: begin
          if (cnt == CNT_W'(1)) begin
            pb_idx <= '0;
            state  <= ST_PROG_RD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_PROG_RD: state <= ST_PROG_WR;
        ST_PROG_WR: begin
          if (pb_idx == pb_len) begin
            state <= ST_IDLE;
          end else begin
            pb_idx <= pb_idx + 1'b1;
            state  <= ST_PROG_RD;
          end
        end
        ST_LOCKING: begin
          if (cnt == CNT_W'(1)) state <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // read path registers
  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= 8'h80;
      sel_q  <= 1'b0;
    end else begin
      stat_q <= status_now;
      sel_q  <= rd_stat;
    end
  end

  assign bus_rdata = sel_q ? stat_q : mem_q;
endmodule

// File: rtl/nor_cmd_model_chk.sv
module nor_cmd_model_chk
  import nor_cmd_pkg::*;
#(
  parameter int CNT_W     = 6,
  parameter int NUM_BLKS  = 4,
  parameter int BLK_IDX_W = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 bus_we,
  input logic [7:0]           bus_wdata,
  input state_t               state,
  input logic                 rd_stat,
  input logic [CNT_W-1:0]     cnt,
  input logic                 err_e,
  input logic                 err_p,
  input logic                 err_l,
  input logic                 arr_we,
  input logic [BLK_IDX_W-1:0] arr_wblk,
  input logic [NUM_BLKS-1:0]  locked,
  input logic                 rd_ready
);
  // R3: a status read taken while erasing shows busy on the port
  p_busy_seen_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_stat && state == ST_ERASING) |=> !rd_ready);

  // R4: erase time advances by one per cycle unless a suspend arrives
  p_erase_tick_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ERASING && !(bus_we && bus_wdata == CMD_SUSPEND) && cnt > CNT_W'(1))
    |=> (cnt == $past(cnt) - 1'b1));

  // R11: remaining erase time is frozen while suspended
  p_susp_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ESUSP) |=> $stable(cnt));

  // R9: the array is never written inside a locked block
  p_lock_guard_r9: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> !locked[arr_wblk]);

  // R7: wrong erase confirm flags both sequence error bits
  p_bad_cfm_r7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ERASE_CFM && bus_we && bus_wdata != CMD_CONFIRM) |=> (err_e && err_p));

  // R10: a clear while idle drops every error flag
  p_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && bus_we && bus_wdata == CMD_CLEAR) |=> (!err_e && !err_p && !err_l));
endmodule

bind nor_cmd_model nor_cmd_model_chk #(
  .CNT_W(CNT_W), .NUM_BLKS(NUM_BLKS), .BLK_IDX_W(BLK_IDX_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .state(state), .rd_stat(rd_stat), .cnt(cnt),
  .err_e(err_e), .err_p(err_p), .err_l(err_l),
  .arr_we(arr_we), .arr_wblk(arr_waddr[ADDR_W-1:BLK_BITS]),
  .locked(locked), .rd_ready(bus_rdata[7])
);

// File: tb/test_nor_cmd_model.sv
module test_nor_cmd_model;
  localparam int BLK_BITS  = 4;
  localparam int NUM_BLKS  = 4;
  localparam int BUF_DEPTH = 8;
  localparam int T_ERASE   = 40;
  localparam int T_PROG    = 12;
  localparam int T_LOCK    = 6;
  localparam int ADDR_W    = $clog2(NUM_BLKS) + BLK_BITS;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0]        bus_wdata = '0;
  logic [7:0]        bus_rdata;

  int   n_chk = 0;
  int   n_fail = 0;
  logic rd_strobe = 1'b0;
  logic strobe_d = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  nor_cmd_model #(
    .BLK_BITS(BLK_BITS), .NUM_BLKS(NUM_BLKS), .BUF_DEPTH(BUF_DEPTH),
    .T_ERASE(T_ERASE), .T_PROG(T_PROG), .T_LOCK(T_LOCK)
  ) i_nor_cmd_model (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic tally(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // monitor: compares read results one cycle after the address
  always @(posedge clk) strobe_d <= rd_strobe;
  always @(negedge clk) begin
    if (strobe_d) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      tally(bus_rdata === e, t, bus_rdata, e);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = 8'(d); rd_strobe = 1'b0;
  endtask

  task automatic rd(input int a, input int e, input string tag);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = ADDR_W'(a); rd_strobe = 1'b1;
    exp_q.push_back(8'(e));
    tag_q.push_back(tag);
  endtask

  task automatic nop(input int n);
    repeat (n) begin
      @(negedge clk);
      bus_we = 1'b0; rd_strobe = 1'b0;
    end
  endtask

  task automatic wait_ready(input string tag);
    logic [7:0] v;
    int k;
    k = 0;
    v = 8'h00;
    while (!v[7] && k < 200) begin
      @(negedge clk);
      bus_we = 1'b0; rd_strobe = 1'b0; bus_addr = '0;
      @(negedge clk);
      v = bus_rdata;
      k++;
    end
    if (!v[7]) tally(1'b0, tag, v, 8'h80);
  endtask

  task automatic prog(input int a, input int n, input logic [7:0] w [4]);
    wr(a, 8'hE8);
    wr(a, n - 1);
    for (int i = 0; i < n; i++) wr(a + i, w[i]);
    wr(a, 8'hD0);
    wait_ready("R5 program completes");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    nop(4);
    rst = 1'b0;
    // R1 reset state and R13 ignored idle command
    rd(3, 8'hFF, "R1 array mode after reset");
    wr(0, 8'h12);
    rd(5, 8'hFF, "R13 unknown command ignored");
    wr(0, 8'h70);
    rd(0, 8'h80, "R1 reset status");

    // R5 buffered program, AND semantics, wrap in block
    prog(2, 4, '{8'hA5, 8'h3C, 8'hF0, 8'h0F});
    rd(0, 8'h80, "R5 status after program");
    wr(0, 8'hFF);
    rd(2, 8'hA5, "R2 R5 first word");
    rd(5, 8'h0F, "R5 last word");
    prog(2, 1, '{8'h0F, 8'h00, 8'h00, 8'h00});
    wr(0, 8'hFF);
    rd(2, 8'h05, "R5 program ANDs with old value");
    prog(15, 2, '{8'h11, 8'h22, 8'h00, 8'h00});
    wr(0, 8'hFF);
    rd(15, 8'h11, "R5 word at block end");
    rd(0, 8'h22, "R5 wrap to block start");
    rd(16, 8'hFF, "R5 next block untouched");

    // R6 oversize count, R10 clear
    wr(0, 8'hE8);
    wr(0, BUF_DEPTH);
    rd(0, 8'hB0, "R6 oversize count error");
    wr(0, 8'h50);
    rd(0, 8'h80, "R10 clear drops errors");

    // R7 wrong confirm bytes
    wr(0, 8'h20);
    wr(0, 8'h33);
    rd(0, 8'hB0, "R7 bad erase confirm");
    wr(0, 8'h50);
    wr(5, 8'hE8);
    wr(5, 0);
    wr(5, 8'h00);
    wr(5, 8'h99);
    rd(0, 8'hB0, "R7 bad program confirm");
    wr(0, 8'hFF);
    rd(5, 8'h0F, "R7 array unchanged");
    wr(0, 8'h50);

    // R8 lock with exact busy time, R9 protection, R10 sticky
    wr(32, 8'h60);
    wr(32, 8'h01);
    nop(T_LOCK - 1);
    rd(0, 8'h00, "R8 R3 lock busy last cycle");
    rd(0, 8'h80, "R8 lock done");
    prog(33, 1, '{8'h00, 8'h00, 8'h00, 8'h00});
    rd(0, 8'h82, "R9 program on locked block");
    wr(32, 8'h20);
    wr(32, 8'hD0);
    wr(0, 8'h70);
    rd(0, 8'h82, "R10 error stays sticky");
    wr(0, 8'h50);
    rd(0, 8'h80, "R10 cleared");
    wr(0, 8'hFF);
    rd(33, 8'hFF, "R9 locked block unchanged");
    wr(32, 8'h60);
    wr(32, 8'hD0);
    wait_ready("R8 unlock completes");
    prog(33, 1, '{8'h3C, 8'h00, 8'h00, 8'h00});
    wr(0, 8'hFF);
    rd(33, 8'h3C, "R8 unlocked block programs");

    // R4 erase with R12 status command in flight
    wr(0, 8'h20);
    wr(0, 8'hD0);
    wr(0, 8'h70);
    nop(T_ERASE - 2);
    rd(0, 8'h00, "R12 R3 erase busy in last cycle");
    rd(0, 8'h80, "R4 erase ready on time");
    wr(0, 8'hFF);
    rd(2, 8'hFF, "R4 erased byte");
    rd(15, 8'hFF, "R4 erased block end");
    rd(33, 8'h3C, "R4 other block kept");

    // R11 suspend and resume
    prog(50, 1, '{8'h77, 8'h00, 8'h00, 8'h00});
    prog(20, 1, '{8'h5A, 8'h00, 8'h00, 8'h00});
    wr(16, 8'h20);
    wr(16, 8'hD0);
    nop(3);
    wr(0, 8'hB0);
    rd(0, 8'hC0, "R11 suspended status");
    wr(0, 8'h20);
    wr(0, 8'h70);
    rd(0, 8'hC0, "R13 command ignored while suspended");
    wr(0, 8'hFF);
    rd(50, 8'h77, "R11 read other block while suspended");
    rd(20, 8'h5A, "R11 target block not yet erased");
    wr(0, 8'hD0);
    nop(T_ERASE - 3 - 1);
    rd(0, 8'h00, "R11 busy in last remaining cycle");
    rd(0, 8'h80, "R11 ready after remaining time");
    wr(0, 8'hFF);
    rd(20, 8'hFF, "R11 erase finished after resume");
    rd(50, 8'h77, "R11 other block kept");

    nop(3);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: %0d reads left, expected 0", exp_q.size());
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule